// File: doc/BRIEF.md
# Parallel Host Port with Paged Display Memory

This block connects an 8-bit microprocessor bus to a paged display memory of 132 columns by 9 pages of 8 bits. The last page is a one-bit icon row. One input picks the bus style. In strobe-and-direction style, an active-high enable starts the access and a direction line gives read or write. In split-strobe style, separate active-low read and write strobes start the access. Every access is one of four kinds, set by the data/command select and the direction: display write, display read, command write, or status read.

Display reads go through a one-byte holder, so each read returns the byte that the previous read fetched. Display writes pass through the same holder and reach memory one clock later. Command writes set the column pointer (one command for each nibble), the page pointer and the scan start line. The column pointer steps once per display access and stops at its last column. A status read reports a short busy window after each command write.

All host inputs are sampled on `clk`. An access starts at the first clock edge where the chip is selected and a strobe is active, and the previous edge saw no active strobe.

Top module: `lcd_host_port`

## Requirements
- R1: While `sel_n` is 1 or `sel` is 0, no access starts: memory, pointers, start line and holder are unchanged. `bus_oe` is 0 in every cycle that follows a cycle with the chip deselected.
- R2: With `mode80` = 0, an access starts on the first sampled edge with `strobe` = 1. `dir_rd` = 1 selects read and 0 selects write.
- R3: With `mode80` = 1, an access starts on the first sampled edge with `rd_n` or `wr_n` low. `rd_n` low selects read and `wr_n` low selects write. `bus_oe` is 1 in the cycle after each edge that sees a selected active read strobe.
- R4: `dc` = 1 makes the access a display access. `dc` = 0 makes it a command write or a status read.
- R5: A status read returns 0x80 when busy and 0x00 otherwise. Every command write, including ignored codes, is busy for status reads that start 1 to BUSY_CYC clocks after it.
- R6: A display read returns the holder's previous contents. The holder is then loaded from the current page and column, or with 0x00 when the column is 132 or more. The column then advances.
- R7: A command that sets either column nibble, or a valid page, clears the holder to 0x00. The next display read therefore returns 0x00 as a dummy read.
- R8: A display write needs no dummy cycle. The byte goes into the holder and is stored at the current page and column. A display read that follows returns that byte.
- R9: Command 0x1N sets column bits 7:4 to N. Command 0x0N sets column bits 3:0 to N.
- R10: The column advances by one after each display read or write, up to 0x83, and then stays there. At a column above 0x83 the column does not change, and writes store nothing.
- R11: Commands 0xB0 to 0xB8 select page 0 to 8. Commands 0xB9 to 0xBF change nothing, and they do not clear the holder. Page 8 stores only bit 0, and its reads return bits 7:1 as 0.
- R12: Commands 0x40 to 0x7F set `start_line` to bits 5:0 of the command. The codes 0x20 to 0x3F and 0x80 to 0xFF (other than valid page codes) change no state apart from busy.
- R13: Synchronous reset sets column, page, start line and holder to 0, clears busy, and drives `bus_oe` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock on which all host signals are sampled |
| rst | input | 1 | Synchronous active-high reset |
| mode80 | input | 1 | 0: enable plus direction style; 1: split read/write strobes |
| sel_n | input | 1 | Active-low chip select |
| sel | input | 1 | Active-high chip select |
| dc | input | 1 | 1: display data access; 0: command or status |
| dir_rd | input | 1 | Direction in enable style, 1 = read |
| strobe | input | 1 | Active-high access enable in enable style |
| rd_n | input | 1 | Active-low read strobe in split style |
| wr_n | input | 1 | Active-low write strobe in split style |
| bus_in | input | 8 | Write data and command bytes from the host |
| bus_out | output | 8 | Registered read data returned to the host |
| bus_oe | output | 1 | Registered output enable for the data bus |
| start_line | output | 6 | Display start line for the scan side |

## Verification
The bench builds the block with its default parameters: 132 columns, 9 pages, 64 lines and a three-clock busy window. With these values, a column set to 0x81 hits the stop at 0x83 within three writes. A nibble pair such as 0x19, 0x00 reaches columns past the memory. A status read issued one access after a command lands inside the busy window. Both bus styles are exercised in the same run, each with both ways of deselecting.

// File: rtl/lcdhp_pkg.sv
package lcdhp_pkg;

  typedef enum logic [2:0] {
    ACC_NONE,
    ACC_DRD,
    ACC_DWR,
    ACC_STAT,
    ACC_CMD
  } acc_e;

  typedef enum logic [2:0] {
    OP_NOP,
    OP_COLHI,
    OP_COLLO,
    OP_PAGE,
    OP_START
  } op_e;

  typedef struct packed {
    op_e        op;
    logic [5:0] arg;
  } cmd_t;

  // Classifies one command byte; page codes beyond the page count are dropped.
  function automatic cmd_t decode_cmd(input logic [7:0] c, input int pages);
    cmd_t r;
    r.op  = OP_NOP;
    r.arg = c[5:0];
    if (c[7:6] == 2'b01)
      r.op = OP_START;
    else if (c[7:4] == 4'h1)
      r.op = OP_COLHI;
    else if (c[7:4] == 4'h0)
      r.op = OP_COLLO;
    else if (c[7:4] == 4'hB && int'(c[3:0]) < pages)
      r.op = OP_PAGE;
    return r;
  endfunction

endpackage

// File: rtl/lcdhp_front.sv
module lcdhp_front
  import lcdhp_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic mode80,
  input  logic sel_n,
  input  logic sel,
  input  logic dc,
  input  logic dir_rd,
  input  logic strobe,
  input  logic rd_n,
  input  logic wr_n,
  output acc_e ev,
  output logic oe_q
);

  logic chip_on;
  logic act;
  logic is_rd;
  logic act_q;

  assign chip_on = !sel_n && sel;

  // Bus style picks the strobe and the direction source.
  always_comb begin
    if (mode80) begin
      act   = chip_on && (!rd_n || !wr_n);
      is_rd = !rd_n;
    end else begin
      act   = chip_on && strobe;
      is_rd = dir_rd;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      act_q <= 1'b0;
      oe_q  <= 1'b0;
    end else begin
      act_q <= act;
      oe_q  <= act && is_rd;
    end
  end

  always_comb begin
    ev = ACC_NONE;
    if (act && !act_q) begin
      if (dc) ev = is_rd ? ACC_DRD : ACC_DWR;
      else    ev = is_rd ? ACC_STAT : ACC_CMD;
    end
  end

  // R1
  desel_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (sel_n || !sel) |=> !oe_q);

  // R2 R3
  one_start_chk: assert property (@(posedge clk) disable iff (rst)
    (ev != ACC_NONE) |=> (ev == ACC_NONE));

endmodule

// File: rtl/lcdhp_regs.sv
module lcdhp_regs
  import lcdhp_pkg::*;
#(
  parameter  int COLS     = 132,
  parameter  int PAGES    = 9,
  parameter  int LINES    = 64,
  parameter  int BUSY_CYC = 3,
  localparam int PW       = $clog2(PAGES),
  localparam int SW       = $clog2(LINES)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cmd_we,
  input  logic [7:0]    cmd_byte,
  input  logic          step,
  output logic [7:0]    col_q,
  output logic [PW-1:0] page_q,
  output logic [SW-1:0] start_q,
  output logic          busy,
  output logic          addr_set
);

  localparam int          BW       = $clog2(BUSY_CYC + 1);
  localparam logic [7:0]  COL_LAST = 8'(COLS - 1);

  cmd_t          dec;
  logic [BW-1:0] busy_cnt;

  assign dec      = decode_cmd(cmd_byte, PAGES);
  assign addr_set = cmd_we && (dec.op == OP_COLHI || dec.op == OP_COLLO || dec.op == OP_PAGE);
  assign busy     = (busy_cnt != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      col_q   <= '0;
      page_q  <= '0;
      start_q <= '0;
    end else if (cmd_we) begin
      case (dec.op)
        OP_COLHI: col_q[7:4] <= dec.arg[3:0];
        OP_COLLO: col_q[3:0] <= dec.arg[3:0];
        OP_PAGE:  page_q     <= PW'(dec.arg[3:0]);
        OP_START: start_q    <= dec.arg[SW-1:0];
        default:  ;
      endcase
    end else if (step && col_q < COL_LAST) begin
      col_q <= col_q + 8'd1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                busy_cnt <= '0;
    else if (cmd_we)        busy_cnt <= BW'(BUSY_CYC);
    else if (busy_cnt != 0) busy_cnt <= busy_cnt - 1'b1;
  end

  // R10
  col_sat_chk: assert property (@(posedge clk) disable iff (rst)
    (step && col_q == COL_LAST) |=> (col_q == COL_LAST));

  // R11
  page_range_chk: assert property (@(posedge clk) disable iff (rst)
    int'(page_q) < PAGES);

  // R5
  busy_set_chk: assert property (@(posedge clk) disable iff (rst)
    cmd_we |=> busy);

endmodule

// File: rtl/lcdhp_mem.sv
module lcdhp_mem #(
  parameter  int COLS  = 132,
  parameter  int PAGES = 9,
  parameter  int DW    = 8,
  localparam int PW    = $clog2(PAGES),
  localparam int CAW   = $clog2(COLS)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           we,
  input  logic [PW-1:0]  wpage,
  input  logic [CAW-1:0] wcol,
  input  logic [DW-1:0]  wdata,
  input  logic           re,
  input  logic [PW-1:0]  rpage,
  input  logic [CAW-1:0] rcol,
  output logic [DW-1:0]  rdata
);

  localparam int          GPAGES = PAGES - 1;
  localparam int          GDEPTH = GPAGES * COLS;
  localparam int          GAW    = $clog2(GDEPTH);
  localparam logic [PW-1:0] ICON = PW'(GPAGES);

  logic [DW-1:0]  gmem [GDEPTH];
  logic           imem [COLS];
  logic [DW-1:0]  gq;
  logic           iq;
  logic           icon_q;
  logic [GAW-1:0] widx;
  logic [GAW-1:0] ridx;
  logic           w_icon;
  logic           r_icon;

  assign w_icon = (wpage == ICON);
  assign r_icon = (rpage == ICON);
  assign widx   = GAW'(wpage) * GAW'(COLS) + GAW'(wcol);
  assign ridx   = GAW'(rpage) * GAW'(COLS) + GAW'(rcol);

  // Graphic pages: one byte per column, synchronous read.
  always_ff @(posedge clk) begin
    if (we && !w_icon) gmem[widx] <= wdata;
    if (re) gq <= gmem[ridx];
  end

  // Icon row: one bit per column.
  always_ff @(posedge clk) begin
    if (we && w_icon) imem[wcol] <= wdata[0];
    if (re) iq <= imem[rcol];
  end

  always_ff @(posedge clk) begin
    if (rst)     icon_q <= 1'b0;
    else if (re) icon_q <= r_icon;
  end

  assign rdata = icon_q ? {{(DW-1){1'b0}}, iq} : gq;

  // R10
  wr_in_range_chk: assert property (@(posedge clk) disable iff (rst)
    we |-> (int'(wcol) < COLS));

endmodule

// File: rtl/lcd_host_port.sv
module lcd_host_port
  import lcdhp_pkg::*;
#(
  parameter  int COLS     = 132,
  parameter  int PAGES    = 9,
  parameter  int LINES    = 64,
  parameter  int BUSY_CYC = 3,
  localparam int DW       = 8,
  localparam int SW       = $clog2(LINES)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          mode80,
  input  logic          sel_n,
  input  logic          sel,
  input  logic          dc,
  input  logic          dir_rd,
  input  logic          strobe,
  input  logic          rd_n,
  input  logic          wr_n,
  input  logic [DW-1:0] bus_in,
  output logic [DW-1:0] bus_out,
  output logic          bus_oe,
  output logic [SW-1:0] start_line
);

  localparam int PW  = $clog2(PAGES);
  localparam int CAW = $clog2(COLS);

  acc_e           ev;
  logic [7:0]     col;
  logic [PW-1:0]  page;
  logic           busy;
  logic           addr_set;
  logic           col_ok;
  logic [DW-1:0]  holder;
  logic [DW-1:0]  mem_q;
  logic           rd_pend;
  logic           rd_ok_q;
  logic           wr_pend;
  logic [PW-1:0]  wr_page_q;
  logic [CAW-1:0] wr_col_q;

  lcdhp_front u_front (
    .clk    (clk),
    .rst    (rst),
    .mode80 (mode80),
    .sel_n  (sel_n),
    .sel    (sel),
    .dc     (dc),
    .dir_rd (dir_rd),
    .strobe (strobe),
    .rd_n   (rd_n),
    .wr_n   (wr_n),
    .ev     (ev),
    .oe_q   (bus_oe)
  );

  lcdhp_regs #(
    .COLS     (COLS),
    .PAGES    (PAGES),
    .LINES    (LINES),
    .BUSY_CYC (BUSY_CYC)
  ) u_regs (
    .clk      (clk),
    .rst      (rst),
    .cmd_we   (ev == ACC_CMD),
    .cmd_byte (bus_in),
    .step     (ev == ACC_DRD || ev == ACC_DWR),
    .col_q    (col),
    .page_q   (page),
    .start_q  (start_line),
    .busy     (busy),
    .addr_set (addr_set)
  );

  assign col_ok = (int'(col) < COLS);

  lcdhp_mem #(
    .COLS  (COLS),
    .PAGES (PAGES),
    .DW    (DW)
  ) u_mem (
    .clk   (clk),
    .rst   (rst),
    .we    (wr_pend),
    .wpage (wr_page_q),
    .wcol  (wr_col_q),
    .wdata (holder),
    .re    (ev == ACC_DRD && col_ok),
    .rpage (page),
    .rcol  (col[CAW-1:0]),
    .rdata (mem_q)
  );

  // Holder pipeline: reads hand out the old byte and refill one clock later;
  // writes park the byte and commit it on the next clock.
  always_ff @(posedge clk) begin
    if (rst) begin
      holder    <= '0;
      bus_out   <= '0;
      rd_pend   <= 1'b0;
      rd_ok_q   <= 1'b0;
      wr_pend   <= 1'b0;
      wr_page_q <= '0;
      wr_col_q  <= '0;
    end else begin
      rd_pend <= 1'b0;
      wr_pend <= 1'b0;
      case (ev)
        ACC_DRD: begin
          bus_out <= holder;
          rd_pend <= 1'b1;
          rd_ok_q <= col_ok;
        end
        ACC_DWR: begin
          holder    <= bus_in;
          wr_pend   <= col_ok;
          wr_page_q <= page;
          wr_col_q  <= col[CAW-1:0];
        end
        ACC_STAT: bus_out <= {busy, {(DW-1){1'b0}}};
        ACC_CMD:  if (addr_set) holder <= '0;
        default:  ;
      endcase
      if (rd_pend) holder <= rd_ok_q ? mem_q : '0;
    end
  end

  // R7
  hold_clear_chk: assert property (@(posedge clk) disable iff (rst)
    addr_set |=> (holder == '0));

endmodule

// File: tb/lcd_host_port_bench.sv
module lcd_host_port_bench;
  localparam int COLS = 132, PAGES = 9, LINES = 64, BUSY_CYC = 3;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst = 1'b1, mode80 = 1'b0, sel_n = 1'b0, sel = 1'b1, dc = 1'b0;
  logic dir_rd = 1'b0, strobe = 1'b0, rd_n = 1'b1, wr_n = 1'b1;
  logic [7:0] bus_in = 8'h00;
  logic [7:0] bus_out;
  logic       bus_oe;
  logic [5:0] start_line;
  logic [7:0] got;

  int total = 0, bad = 0;
  int m_col = 0, m_page = 0, m_start = 0, m_busy = 0, m_hold = 0, m_oe = 0;
  int m_mem [PAGES][COLS];

  lcd_host_port #(.COLS(COLS), .PAGES(PAGES), .LINES(LINES), .BUSY_CYC(BUSY_CYC)) u_lcd_host_port (
    .clk(clk), .rst(rst), .mode80(mode80), .sel_n(sel_n), .sel(sel), .dc(dc),
    .dir_rd(dir_rd), .strobe(strobe), .rd_n(rd_n), .wr_n(wr_n),
    .bus_in(bus_in), .bus_out(bus_out), .bus_oe(bus_oe), .start_line(start_line)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Reference model, compared every clock between edges.
  always @(posedge clk) begin
    if (m_busy > 0) m_busy--;
    #5;
    if (!rst) begin
      chk("R1/R3 bus_oe", int'(bus_oe), m_oe);
      chk("R12 start_line", int'(start_line), m_start);
    end
  end

  function automatic void m_step();
    if (m_col < COLS - 1) m_col++;
  endfunction

  function automatic void m_cmd(input logic [7:0] c);
    m_busy = BUSY_CYC + 1;
    if (c[7:6] == 2'b01) m_start = int'(c[5:0]);
    else if (c[7:4] == 4'h1) begin m_col = (m_col & 'h0F) | (int'(c[3:0]) << 4); m_hold = 0; end
    else if (c[7:4] == 4'h0) begin m_col = (m_col & 'hF0) | int'(c[3:0]); m_hold = 0; end
    else if (c[7:4] == 4'hB && int'(c[3:0]) < PAGES) begin m_page = int'(c[3:0]); m_hold = 0; end
  endfunction

  task automatic acc(input string req, input bit d, input bit rd, input logic [7:0] wdat,
                     input bit sn, input bit s);
    int ex;
    bit on;
    on = !sn && s;
    ex = 0;
    @(negedge clk);
    sel_n = sn; sel = s; dc = d; bus_in = wdat;
    if (mode80) begin rd_n = !rd; wr_n = rd; end
    else begin dir_rd = rd; strobe = 1'b1; end
    if (on) begin
      if (d && rd) begin
        ex = m_hold;
        m_hold = (m_col < COLS) ? m_mem[m_page][m_col] : 0;
        m_step();
      end else if (d) begin
        m_hold = int'(wdat);
        if (m_col < COLS) m_mem[m_page][m_col] = (m_page == PAGES - 1) ? int'(wdat[0]) : int'(wdat);
        m_step();
      end else if (rd) begin
        ex = (m_busy > 0) ? 'h80 : 0;
      end else begin
        m_cmd(wdat);
      end
    end
    m_oe = (on && rd) ? 1 : 0;
    @(negedge clk);
    got = bus_out;
    if (on && rd) chk(req, int'(got), ex);
    strobe = 1'b0; rd_n = 1'b1; wr_n = 1'b1; sel_n = 1'b0; sel = 1'b1;
    m_oe = 0;
  endtask

  task automatic cmd(input logic [7:0] c);  acc("cmd", 1'b0, 1'b0, c, 1'b0, 1'b1); endtask
  task automatic wr(input logic [7:0] v);   acc("wr", 1'b1, 1'b0, v, 1'b0, 1'b1); endtask
  task automatic rd(input string req);      acc(req, 1'b1, 1'b1, 8'h00, 1'b0, 1'b1); endtask
  task automatic stat(input string req);    acc(req, 1'b0, 1'b1, 8'h00, 1'b0, 1'b1); endtask
  task automatic set_col(input int c);      cmd(8'h10 | 8'(c >> 4)); cmd(8'(c & 'hF)); endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; strobe = 1'b0; rd_n = 1'b1; wr_n = 1'b1; m_oe = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    m_col = 0; m_page = 0; m_start = 0; m_busy = 0; m_hold = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    do_reset();
    // R13 reset state
    @(negedge clk);
    chk("R13 bus_oe after reset", int'(bus_oe), 0);
    chk("R13 start_line after reset", int'(start_line), 0);
    stat("R13 R5 idle status");
    rd("R13 holder zero after reset");

    // R2 R8 R9: enable style, fill page 0 columns 0..7
    cmd(8'hB0); set_col(0);
    for (int i = 0; i < 8; i++) wr(8'(8'hA0 + i * 7));
    set_col(0);
    rd("R7 dummy read after column set");
    for (int i = 0; i < 7; i++) rd("R6 R2 pipelined read");

    // R3 R4: split strobes on page 3 at column 0x20
    mode80 = 1'b1;
    cmd(8'hB3); set_col('h20);
    for (int i = 0; i < 4; i++) wr(8'(8'h3C ^ (i * 8'h11)));
    set_col('h20);
    rd("R7 R3 dummy read");
    for (int i = 0; i < 4; i++) rd("R6 R3 read");
    set_col('h30); wr(8'h5A);
    rd("R8 read after write returns written byte");

    // R10 saturation at the last column
    set_col('h81);
    wr(8'h11); wr(8'h22); wr(8'h33); wr(8'h44);
    set_col('h81);
    for (int i = 0; i < 5; i++) rd("R10 saturated column read");

    // R10 column beyond memory
    set_col('h90); wr(8'h55);
    rd("R10 holder after out-of-range write");
    rd("R10 out-of-range read loads zero");

    // R11 icon row
    mode80 = 1'b0;
    cmd(8'hB8); set_col(5); wr(8'hFF);
    set_col(5);
    rd("R11 icon dummy"); rd("R11 icon keeps bit 0 only");

    // R11 invalid page leaves page and holder alone
    cmd(8'hB0); set_col(0);
    rd("R7 dummy"); rd("R6 page 0 col 0");
    cmd(8'hBA);
    rd("R11 invalid page ignored");

    // R12 start line and ignored codes
    cmd(8'h45); cmd(8'h7F); cmd(8'h20); cmd(8'h3F); cmd(8'h80); cmd(8'hC7); cmd(8'hE3);
    rd("R12 R9 ignored codes keep column");

    // R5 busy window
    cmd(8'h40);
    stat("R5 busy right after command");
    repeat (6) @(negedge clk);
    stat("R5 idle after window");

    // R1 deselect both ways, both styles
    acc("R1 write sel_n high", 1'b1, 1'b0, 8'hEE, 1'b1, 1'b1);
    acc("R1 read sel low", 1'b1, 1'b1, 8'h00, 1'b0, 1'b0);
    acc("R1 cmd sel low", 1'b0, 1'b0, 8'h7A, 1'b0, 1'b0);
    mode80 = 1'b1;
    acc("R1 split read deselected", 1'b1, 1'b1, 8'h00, 1'b1, 1'b1);
    acc("R1 split write deselected", 1'b1, 1'b0, 8'hEE, 1'b1, 1'b0);
    set_col(0);
    rd("R1 dummy"); rd("R1 memory untouched while deselected");
    mode80 = 1'b0;

    // R13 reset in the middle of a run
    cmd(8'hB3); set_col(9); cmd(8'h55);
    do_reset();
    @(negedge clk);
    chk("R13 start_line cleared", int'(start_line), 0);
    rd("R13 holder cleared"); rd("R13 pointers back at page 0 col 0");

    repeat (3) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule